// File: doc/BRIEF.md
# Masked Multi-Address I2C Slave Address Matcher

This block decides whether the device is being addressed by the first byte of an I2C transfer. Once the bus front end has shifted in the byte that follows a START, it presents that byte for one cycle with `addr_valid`. The matcher compares the upper seven bits with four programmable slave addresses. Each slot has its own don't-care mask, so one slot can answer a whole family of addresses. The all-zero general call address is handled on a separate path that the masks never touch.

The result is registered and held until the next address byte arrives. It gives a match flag, the index of the slot that matched and a general-call flag. When a match is reported, the full received byte, including its read/write bit, is kept. Software can then see which concrete address caused the hit. A small write/read port gives access to the four address registers and the four mask registers. The acknowledge-enable input gates everything: with it low, the device answers no address at all.

Top module: `i2c_multi_addr_match`

## Requirements
- R1: Each of the four slots has an 8-bit address register, selected by `cfg_sel`=0 and `cfg_slot`. Bits 7:1 hold the 7-bit address and bit 0 is that slot's general-call enable. A write on `cfg_we` stores all 8 bits, and `cfg_rdata` returns them combinationally.
- R2: Each slot has a mask register, selected by `cfg_sel`=1. Bits 7:1 are stored. Bit 0 ignores writes and always reads back as 0.
- R3: After reset, all address and mask registers read 0, and `match`, `gen_call`, `match_slot` and `rx_byte` are 0.
- R4: A slot matches when every bit of `addr_byte[7:1]` whose mask bit is 0 equals the slot's address bit. A mask bit of 1 makes that position don't-care. With a zero mask, only the exact address matches.
- R5: `addr_byte[0]` (read/write) never takes part in any compare, and it is captured as `rx_byte[0]`.
- R6: When several slots match, `match_slot` gives the lowest-numbered one.
- R7: A received address of 0000000 raises `gen_call` and `match` when at least one slot has its general-call enable set. `match_slot` then names the lowest such slot. This takes priority over slot compares, and no mask changes the outcome.
- R8: A received address of 0000000 never matches through a slot compare, whatever the masks are. Without any general-call enable it produces no match.
- R9: With `ack_en`=0 when `addr_valid` is high, `match` and `gen_call` become 0 and `rx_byte` keeps its value.
- R10: Results update on the clock edge where `addr_valid` is 1 and hold until the next such edge. `rx_byte` loads only when a match or general call is reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 = address register, 1 = mask register |
| cfg_slot | input | 2 | Slot index for write and read |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of selected register |
| addr_valid | input | 1 | Address byte present this cycle |
| addr_byte | input | 8 | Received first byte (address + R/W) |
| ack_en | input | 1 | Acknowledge enable; 0 blocks all matches |
| match | output | 1 | Device addressed (slot or general call) |
| match_slot | output | 2 | Slot index of the match |
| gen_call | output | 1 | General call detected |
| rx_byte | output | 8 | Received byte of the last reported match |

## Verification
The hardest situation to reach is an all-zero address when the masks would let a slot accept it. Only the general-call path may answer that address, and the result must also follow the general-call enables rather than the masks. The stimulus first programs a slot with a fully open mask and no enable, and checks that the zero address is refused. It then sets the enable only on the highest slot, while a lower slot remains open to everything. That shows the priority and the reported index. The bench also checks that `rx_byte` survives both misses and blocked bytes.

// File: rtl/i2c_match_pkg.sv
package i2c_match_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = ADDR_W + 1;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/i2c_slot_regs.sv
module i2c_slot_regs
  import i2c_match_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic                           sel,
  input  logic [IDX_W-1:0]               slot,
  input  logic [BYTE_W-1:0]              wdata,
  output logic [BYTE_W-1:0]              rdata,
  output logic [SLOTS-1:0][ADDR_W-1:0]   slot_addr,
  output logic [SLOTS-1:0][ADDR_W-1:0]   slot_mask,
  output logic [SLOTS-1:0]               slot_gc_en
);
  logic [SLOTS-1:0][BYTE_W-1:0] addr_q, addr_d;
  logic [SLOTS-1:0][ADDR_W-1:0] mask_q, mask_d;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit_sel;
    assign hit_sel = we && (slot == IDX_W'(s));

    always_comb begin
      addr_d[s] = addr_q[s];
      mask_d[s] = mask_q[s];
      if (hit_sel && (cfg_sel_e'(sel) == SEL_ADDR)) addr_d[s] = wdata;
      if (hit_sel && (cfg_sel_e'(sel) == SEL_MASK)) mask_d[s] = wdata[BYTE_W-1:1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q[s] <= '0;
        mask_q[s] <= '0;
      end else if (hit_sel) begin
        addr_q[s] <= addr_d[s];
        mask_q[s] <= mask_d[s];
      end
    end

    assign slot_addr[s]  = addr_q[s][BYTE_W-1:1];
    assign slot_gc_en[s] = addr_q[s][0];
    assign slot_mask[s]  = mask_q[s];
  end

  always_comb begin
    rdata = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (slot == IDX_W'(s)) begin
        rdata = (cfg_sel_e'(sel) == SEL_ADDR) ? addr_q[s] : {mask_q[s], 1'b0};
      end
    end
  end
endmodule

// File: rtl/i2c_slot_cmp.sv
module i2c_slot_cmp
  import i2c_match_pkg::*;
(
  input  logic [ADDR_W-1:0] rx_addr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [ADDR_W-1:0] dont_care,
  output logic              hit
);
  logic [ADDR_W-1:0] diff;
  logic              reserved_zero;

  always_comb begin
    diff          = (rx_addr ^ own_addr) & ~dont_care;
    reserved_zero = (rx_addr == '0);
    hit           = !reserved_zero && (diff == '0);
  end
endmodule

// File: rtl/i2c_match_resolve.sv
module i2c_match_resolve
  import i2c_match_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic [SLOTS-1:0] slot_hit,
  input  logic [SLOTS-1:0] gc_en,
  input  logic             rx_is_zero,
  output logic             any_hit,
  output logic             gc_hit,
  output logic [IDX_W-1:0] win_idx
);
  logic [IDX_W-1:0] hit_idx, gc_idx;

  always_comb begin
    hit_idx = '0;
    gc_idx  = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (slot_hit[s]) hit_idx = IDX_W'(s);
      if (gc_en[s])    gc_idx  = IDX_W'(s);
    end
    gc_hit  = rx_is_zero && (|gc_en);
    any_hit = gc_hit || (|slot_hit);
    win_idx = gc_hit ? gc_idx : (|slot_hit ? hit_idx : '0);
  end
endmodule

// File: rtl/i2c_multi_addr_match.sv
module i2c_multi_addr_match
  import i2c_match_pkg::*;
#(
  parameter int unsigned SLOTS = 4,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [IDX_W-1:0]  cfg_slot,
  input  logic [BYTE_W-1:0] cfg_wdata,
  output logic [BYTE_W-1:0] cfg_rdata,
  input  logic              addr_valid,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              ack_en,
  output logic              match,
  output logic [IDX_W-1:0]  match_slot,
  output logic              gen_call,
  output logic [BYTE_W-1:0] rx_byte
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [SLOTS-1:0][ADDR_W-1:0] slot_addr, slot_mask;
  logic [SLOTS-1:0]             slot_gc_en, slot_hit;

  i2c_slot_regs #(.SLOTS(SLOTS)) u_regs (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .we         (cfg_we),
    .sel        (cfg_sel),
    .slot       (cfg_slot),
    .wdata      (cfg_wdata),
    .rdata      (cfg_rdata),
    .slot_addr  (slot_addr),
    .slot_mask  (slot_mask),
    .slot_gc_en (slot_gc_en)
  );

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    i2c_slot_cmp u_cmp (
      .rx_addr   (addr_byte[BYTE_W-1:1]),
      .own_addr  (slot_addr[s]),
      .dont_care (slot_mask[s]),
      .hit       (slot_hit[s])
    );
  end

  logic             any_hit, gc_hit;
  logic [IDX_W-1:0] win_idx;

  i2c_match_resolve #(.SLOTS(SLOTS)) u_resolve (
    .slot_hit   (slot_hit),
    .gc_en      (slot_gc_en),
    .rx_is_zero (addr_byte[BYTE_W-1:1] == '0),
    .any_hit    (any_hit),
    .gc_hit     (gc_hit),
    .win_idx    (win_idx)
  );

  logic              match_q, match_d, gc_q, gc_d;
  logic [IDX_W-1:0]  slot_q, slot_d;
  logic [BYTE_W-1:0] rx_q, rx_d;
  logic              res_en, rx_en;

  always_comb begin
    res_en  = addr_valid;
    rx_en   = addr_valid && ack_en && any_hit;
    match_d = ack_en && any_hit;
    gc_d    = ack_en && gc_hit;
    slot_d  = (ack_en && any_hit) ? win_idx : '0;
    rx_d    = addr_byte;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      match_q <= 1'b0;
      gc_q    <= 1'b0;
      slot_q  <= '0;
    end else if (res_en) begin
      match_q <= match_d;
      gc_q    <= gc_d;
      slot_q  <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)  rx_q <= '0;
    else if (rx_en)  rx_q <= rx_d;
  end

  assign match      = match_q;
  assign gen_call   = gc_q;
  assign match_slot = slot_q;
  assign rx_byte    = rx_q;
endmodule

// File: rtl/i2c_multi_addr_match_checker.sv
module i2c_multi_addr_match_checker #(
  parameter int unsigned IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_sel,
  input logic [7:0]       cfg_rdata,
  input logic             addr_valid,
  input logic             ack_en,
  input logic             match,
  input logic [IDX_W-1:0] match_slot,
  input logic             gen_call,
  input logic [7:0]       rx_byte
);
  a_r2_mask_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_sel |-> (cfg_rdata[0] == 1'b0));

  a_r7_gc_implies_match: assert property (@(posedge clk) disable iff (!rst_n)
    gen_call |-> match);

  a_r8_zero_addr_only_gc: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !gen_call) |-> (rx_byte[7:1] != 7'd0));

  a_r9_ack_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !ack_en) |=> (!match && !gen_call));

  a_r10_hold_match: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> ($stable(match) && $stable(gen_call) && $stable(match_slot)));

  a_r10_rx_loads_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> (match && $past(addr_valid)));
endmodule

bind i2c_multi_addr_match i2c_multi_addr_match_checker #(.IDX_W(IDX_W)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_sel    (cfg_sel),
  .cfg_rdata  (cfg_rdata),
  .addr_valid (addr_valid),
  .ack_en     (ack_en),
  .match      (match),
  .match_slot (match_slot),
  .gen_call   (gen_call),
  .rx_byte    (rx_byte)
);

// File: tb/i2c_multi_addr_match_bench.sv
`timescale 1ns/1ps
module i2c_multi_addr_match_bench;
  logic       clk, rst_n;
  logic       cfg_we, cfg_sel;
  logic [1:0] cfg_slot;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic       addr_valid, ack_en;
  logic [7:0] addr_byte;
  logic       match, gen_call;
  logic [1:0] match_slot;
  logic [7:0] rx_byte;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 0;

  i2c_multi_addr_match u_i2c_multi_addr_match (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_slot(cfg_slot), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .ack_en(ack_en),
    .match(match), .match_slot(match_slot), .gen_call(gen_call),
    .rx_byte(rx_byte)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic sel, input logic [1:0] slot, input logic [7:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_slot = slot; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input string req, input logic sel, input logic [1:0] slot,
                           input logic [7:0] exp);
    @(negedge clk);
    cfg_sel = sel; cfg_slot = slot;
    #1;
    check(req, cfg_rdata, exp);
  endtask

  task automatic send(input logic [7:0] b, input logic ack);
    @(negedge clk);
    addr_valid = 1'b1; addr_byte = b; ack_en = ack;
    @(negedge clk);
    addr_valid = 1'b0; addr_byte = 8'h00; ack_en = 1'b1;
  endtask

  task automatic expect_res(input string req, input logic m, input logic [1:0] sl,
                            input logic gc, input logic [7:0] rx);
    check({req, " match"}, match, m);
    check({req, " slot"}, match_slot, sl);
    check({req, " gen_call"}, gen_call, gc);
    check({req, " rx_byte"}, rx_byte, rx);
  endtask

  task automatic t_reset();
    for (int s = 0; s < 4; s++) begin
      cfg_check("R3 addr reset", 1'b0, 2'(s), 8'h00);
      cfg_check("R3 mask reset", 1'b1, 2'(s), 8'h00);
    end
    expect_res("R3 outputs", 1'b0, 2'd0, 1'b0, 8'h00);
    send(8'h00, 1'b1);
    expect_res("R8 zero after reset", 1'b0, 2'd0, 1'b0, 8'h00);
  endtask

  task automatic t_regs();
    cfg_write(1'b0, 2'd1, 8'hA5);
    cfg_check("R1 addr readback", 1'b0, 2'd1, 8'hA5);
    cfg_write(1'b1, 2'd1, 8'hFF);
    cfg_check("R2 mask bit0 ignored", 1'b1, 2'd1, 8'hFE);
    cfg_check("R1 other slot untouched", 1'b0, 2'd2, 8'h00);
    cfg_write(1'b0, 2'd1, 8'h00);
    cfg_write(1'b1, 2'd1, 8'h00);
  endtask

  task automatic t_exact();
    cfg_write(1'b0, 2'd0, 8'hA0);
    send(8'hA0, 1'b1);
    expect_res("R4 exact hit", 1'b1, 2'd0, 1'b0, 8'hA0);
    send(8'hA1, 1'b1);
    expect_res("R5 rw ignored", 1'b1, 2'd0, 1'b0, 8'hA1);
    send(8'hA2, 1'b1);
    expect_res("R10 miss keeps rx", 1'b0, 2'd0, 1'b0, 8'hA1);
  endtask

  task automatic t_mask();
    cfg_write(1'b0, 2'd2, 8'h60);
    cfg_write(1'b1, 2'd2, 8'h06);
    send(8'h67, 1'b1);
    expect_res("R4 masked hit", 1'b1, 2'd2, 1'b0, 8'h67);
    send(8'h68, 1'b1);
    expect_res("R4 unmasked bit differs", 1'b0, 2'd0, 1'b0, 8'h67);
  endtask

  task automatic t_priority();
    cfg_write(1'b0, 2'd1, 8'h62);
    send(8'h62, 1'b1);
    expect_res("R6 lowest slot", 1'b1, 2'd1, 1'b0, 8'h62);
    send(8'h64, 1'b1);
    expect_res("R6 only slot2", 1'b1, 2'd2, 1'b0, 8'h64);
  endtask

  task automatic t_gc();
    cfg_write(1'b1, 2'd0, 8'hFE);
    send(8'h00, 1'b1);
    expect_res("R8 open mask no gc", 1'b0, 2'd0, 1'b0, 8'h64);
    send(8'h12, 1'b1);
    expect_res("R4 open mask any addr", 1'b1, 2'd0, 1'b0, 8'h12);
    cfg_write(1'b0, 2'd3, 8'h01);
    cfg_write(1'b1, 2'd3, 8'hFE);
    send(8'h00, 1'b1);
    expect_res("R7 gc priority", 1'b1, 2'd3, 1'b1, 8'h00);
    send(8'h01, 1'b1);
    expect_res("R7 gc rw bit", 1'b1, 2'd3, 1'b1, 8'h01);
  endtask

  task automatic t_ack();
    send(8'hA0, 1'b0);
    expect_res("R9 ack blocks slot", 1'b0, 2'd0, 1'b0, 8'h01);
    send(8'h00, 1'b0);
    expect_res("R9 ack blocks gc", 1'b0, 2'd0, 1'b0, 8'h01);
  endtask

  task automatic t_hold();
    send(8'h62, 1'b1);
    repeat (3) @(negedge clk);
    expect_res("R10 hold", 1'b1, 2'd0, 1'b0, 8'h62);
  endtask

  initial begin
    #20000;
    if (!done) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_slot = '0; cfg_wdata = '0;
    addr_valid = 1'b0; addr_byte = '0; ack_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_regs();
    t_exact();
    t_mask();
    t_priority();
    t_gc();
    t_ack();
    t_hold();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule